// File: doc/BRIEF.md
# Von Neumann Debiaser with Stuck Detector

This block sits between a sampled entropy source and whatever collects its output bits. While the source enable is high, it takes one raw bit every N clock cycles. N is a 32-bit interval input, normally driven by a configuration register whose reset value is 0xFFFF. The sampled bits are balanced in non-overlapping pairs. A pair whose two bits differ yields one output bit, shown with a one-cycle strobe. A pair whose two bits are equal is dropped.

A run monitor watches the same sampled stream in parallel. It raises a one-cycle error pulse when 32 consecutive samples are identical.

A single bypass control removes both the balancing and the run check, so every sample goes straight to the output. In bypass the sample interval is held to at least 17 cycles. Dropping the enable clears the interval counter, a half-filled pair and the run count.

Top module: `vn_debias_top`

## Requirements
- R1: With bypass low, a sample is taken on the N-th enabled clock edge after enable rises, and then every N edges after that. An interval of 0 behaves as 1, so a sample is taken every cycle.
- R2: With bypass high, an interval below 17 is raised to 17. An interval of 17 or more is used unchanged. Consecutive output strobes are therefore exactly the effective interval apart.
- R3: A pair whose first sample is 0 and second is 1 outputs 0. A pair whose first sample is 1 and second is 0 outputs 1. out_bit and out_valid appear in the cycle after the clock edge that takes the second sample, and out_valid lasts one cycle.
- R4: A pair of equal samples (00 or 11) produces no output strobe.
- R5: Pairs never overlap. After each second sample, the next sample opens a new pair.
- R6: run_err pulses for one cycle in the cycle after the 32nd consecutive identical sample. The count restarts at a differing sample and after each pulse, so every further 32 identical samples pulse again.
- R7: With bypass high, every sample is output unchanged and run_err never rises.
- R8: While src_en is low no sample is taken and raw_bit has no effect. Lowering src_en clears the interval counter, any half-filled pair and the run count.
- R9: After reset, out_valid and run_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_en | input | 1 | Entropy source enable; sampling runs only while high |
| raw_bit | input | 1 | Raw bit from the entropy source |
| interval | input | 32 | Clock cycles between samples |
| bypass | input | 1 | 1 = pass samples straight through, no run check |
| out_bit | output | 1 | Balanced (or passed-through) bit |
| out_valid | output | 1 | One-cycle strobe qualifying out_bit |
| run_err | output | 1 | One-cycle pulse on a 32-sample identical run |

## Verification
A pair completion and the end of a 32-sample run can fall on the same sample edge. This happens when an identical run starts on a pair boundary, because the 32nd sample then closes the 16th equal pair. The bench provokes this case by sending 32 ones straight after a completed pair. It expects run_err in that cycle and no output strobe, since the pair is equal. A reference model in the bench, built from the pairing and run rules, predicts both the output queue and the number of error pulses; the monitor compares each strobe and the final pulse count against it.

// File: rtl/vnd_pkg.sv
package vnd_pkg;
    typedef enum logic {
        MODE_BALANCE = 1'b0,
        MODE_PASS    = 1'b1
    } mode_e;

    typedef struct packed {
        logic full;
        logic first;
    } half_pair_t;
endpackage

// File: rtl/vnd_sample_timer.sv
module vnd_sample_timer
    import vnd_pkg::*;
#(
    parameter int IVL_W      = 32,
    parameter int MIN_BYPASS = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_en,
    input  mode_e            mode,
    input  logic [IVL_W-1:0] interval,
    output logic             strobe
);
    typedef struct packed {
        logic [IVL_W-1:0] cnt;
    } timer_s;

    timer_s           st_d, st_q;
    logic [IVL_W-1:0] eff;

    always_comb begin
        eff = interval;
        if (eff == '0) eff = IVL_W'(1);
        if (mode == MODE_PASS && eff < IVL_W'(MIN_BYPASS)) eff = IVL_W'(MIN_BYPASS);
        strobe = src_en && (st_q.cnt >= eff - IVL_W'(1));
        st_d = st_q;
        if (!src_en || strobe) st_d.cnt = '0;
        else                   st_d.cnt = st_q.cnt + IVL_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_no_strobe_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !src_en |-> !strobe);

    assert_bypass_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && mode == MODE_PASS) |=> !strobe);
endmodule

// File: rtl/vnd_pair_balancer.sv
module vnd_pair_balancer
    import vnd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  src_en,
    input  logic  strobe,
    input  mode_e mode,
    input  logic  raw_bit,
    output logic  out_bit,
    output logic  out_valid
);
    typedef struct packed {
        half_pair_t pair;
        logic       bit_o;
        logic       vld;
    } bal_s;

    bal_s st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (!src_en || mode == MODE_PASS) st_d.pair.full = 1'b0;
        if (strobe) begin
            if (mode == MODE_PASS) begin
                st_d.vld   = 1'b1;
                st_d.bit_o = raw_bit;
            end else if (!st_q.pair.full) begin
                st_d.pair.full  = 1'b1;
                st_d.pair.first = raw_bit;
            end else begin
                st_d.pair.full = 1'b0;
                if (st_q.pair.first != raw_bit) begin
                    st_d.vld   = 1'b1;
                    st_d.bit_o = st_q.pair.first;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_bit   = st_q.bit_o;
    assign out_valid = st_q.vld;

    assert_out_needs_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> !out_valid);

    assert_pair_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && st_q.pair.full && mode == MODE_BALANCE) |=> !st_q.pair.full);
endmodule

// File: rtl/vnd_run_monitor.sv
module vnd_run_monitor
    import vnd_pkg::*;
#(
    parameter int RUN_LEN = 32
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  src_en,
    input  logic  strobe,
    input  mode_e mode,
    input  logic  raw_bit,
    output logic  run_err
);
    localparam int CW = $clog2(RUN_LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          last;
        logic          err;
    } run_s;

    run_s st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (!src_en || mode == MODE_PASS) begin
            st_d.cnt = '0;
        end else if (strobe) begin
            if (st_q.cnt == '0 || raw_bit != st_q.last) begin
                st_d.cnt  = CW'(1);
                st_d.last = raw_bit;
            end else if (st_q.cnt == CW'(RUN_LEN - 1)) begin
                st_d.cnt = '0;
                st_d.err = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_err = st_q.err;

    assert_err_after_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> !run_err);

    assert_no_err_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PASS) |=> !run_err);
endmodule

// File: rtl/vn_debias_top.sv
module vn_debias_top
    import vnd_pkg::*;
#(
    parameter int IVL_W      = 32,
    parameter int MIN_BYPASS = 17,
    parameter int RUN_LEN    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_en,
    input  logic             raw_bit,
    input  logic [IVL_W-1:0] interval,
    input  logic             bypass,
    output logic             out_bit,
    output logic             out_valid,
    output logic             run_err
);
    mode_e mode;
    logic  strobe;

    assign mode = bypass ? MODE_PASS : MODE_BALANCE;

    vnd_sample_timer #(.IVL_W(IVL_W), .MIN_BYPASS(MIN_BYPASS)) u_timer (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .mode(mode),
        .interval(interval), .strobe(strobe)
    );

    vnd_pair_balancer u_balancer (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .strobe(strobe), .mode(mode),
        .raw_bit(raw_bit), .out_bit(out_bit), .out_valid(out_valid)
    );

    vnd_run_monitor #(.RUN_LEN(RUN_LEN)) u_run (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .strobe(strobe), .mode(mode),
        .raw_bit(raw_bit), .run_err(run_err)
    );

    assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && !run_err));
endmodule

// File: tb/vn_debias_top_tb.sv
module vn_debias_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_en = 1'b0;
    logic        raw_bit = 1'b0;
    logic [31:0] interval = 32'd4;
    logic        bypass = 1'b0;
    logic        out_bit, out_valid, run_err;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int exp_err = 0;
    int got_err = 0;
    int gap_exp = 0;
    int prev_vcyc = -1;
    bit m_have = 0;
    bit m_first = 0;
    bit m_last = 0;
    int m_run = 0;
    bit exp_q[$];
    logic [15:0] lfsr = 16'hACE1;

    vn_debias_top u_dut (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .raw_bit(raw_bit),
        .interval(interval), .bypass(bypass),
        .out_bit(out_bit), .out_valid(out_valid), .run_err(run_err)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (run_err) got_err++;
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R8/R4 unexpected strobe", 1, 0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    chk(out_bit == e, "R3/R7 output bit", int'(out_bit), int'(e));
                end
                if (gap_exp != 0 && prev_vcyc >= 0)
                    chk(cyc - prev_vcyc == gap_exp, "R2 strobe spacing", cyc - prev_vcyc, gap_exp);
                prev_vcyc = cyc;
            end
        end
    end

    function automatic int eff_n();
        int n;
        n = (interval == 0) ? 1 : int'(interval);
        if (bypass && n < 17) n = 17;
        return n;
    endfunction

    // Driver with reference model
    task automatic send_bit(input bit b);
        raw_bit = b;
        if (bypass) begin
            exp_q.push_back(b);
        end else begin
            if (m_run == 0 || b != m_last) begin
                m_run = 1;
                m_last = b;
            end else begin
                m_run++;
            end
            if (m_run == 32) begin
                exp_err++;
                m_run = 0;
            end
            if (!m_have) begin
                m_have = 1;
                m_first = b;
            end else begin
                m_have = 0;
                if (m_first != b) exp_q.push_back(m_first);
            end
        end
        repeat (eff_n()) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_rand(input int n);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send_bit(lfsr[0]);
        end
    endtask

    task automatic enable_src(input int ivl, input bit byp);
        interval = 32'(ivl);
        bypass = byp;
        prev_vcyc = -1;
        gap_exp = byp ? eff_n() : 0;
        src_en = 1'b1;
    endtask

    task automatic disable_src();
        src_en = 1'b0;
        m_have = 0;
        m_run = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic phase_end(input string tag);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, {tag, " pending outputs"}, exp_q.size(), 0);
        chk(got_err == exp_err, {tag, " R6 error pulses"}, got_err, exp_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 0, "R9 out_valid at reset", int'(out_valid), 0);
        chk(run_err == 0, "R9 run_err at reset", int'(run_err), 0);

        // R3 R4 R5: fixed pairs then pseudo-random stream, interval 4
        enable_src(4, 0);
        send_bit(0); send_bit(1);
        send_bit(1); send_bit(0);
        send_bit(1); send_bit(1);
        send_bit(0); send_bit(0);
        send_bit(1); send_bit(0); send_bit(0); send_bit(1);
        send_rand(40);
        disable_src();
        phase_end("R3 R4 R5 interval4");

        // R1: interval 0 acts as 1
        enable_src(0, 0);
        send_rand(30);
        disable_src();
        phase_end("R1 interval0");

        // R6: run detection; 31 ones then break, then aligned runs coinciding with pair ends
        enable_src(2, 0);
        for (int i = 0; i < 31; i++) send_bit(1);
        send_bit(0);
        for (int i = 0; i < 64; i++) send_bit(1);
        for (int i = 0; i < 10; i++) send_bit(0);
        disable_src();
        phase_end("R6 runs");

        // R8: disable clears half pair and run count; raw ignored while disabled
        enable_src(3, 0);
        send_bit(1);
        disable_src();
        for (int i = 0; i < 10; i++) begin
            raw_bit = i[0];
            @(negedge clk);
        end
        enable_src(3, 0);
        send_bit(0); send_bit(1);
        for (int i = 0; i < 20; i++) send_bit(1);
        disable_src();
        enable_src(3, 0);
        for (int i = 0; i < 20; i++) send_bit(1);
        disable_src();
        phase_end("R8 disable");

        // R2 R7: bypass clamps interval 3 to 17, passes a long run with no error
        enable_src(3, 1);
        send_rand(6);
        for (int i = 0; i < 36; i++) send_bit(1);
        disable_src();
        phase_end("R2 R7 bypass clamp");

        // R2: bypass with interval 20 unchanged
        enable_src(20, 1);
        send_rand(6);
        disable_src();
        phase_end("R2 bypass interval20");

        finish_up();
    end
endmodule